// File: doc/BRIEF.md
# DRAM Refresh and Initialization Sequencer

This block sits between a memory controller's access path and an asynchronous DRAM. It keeps the DRAM row refresh going on its own. After reset it keeps both strobes high for the power-up quiet period. It then runs a fixed number of CAS-before-RAS warm-up cycles that need no arbiter grant. Only after the last warm-up cycle does it declare the memory ready.

In normal operation an interval timer adds one owed refresh per refresh interval to a small backlog counter. While refreshes are owed and the engine is idle, the block raises a request towards the arbiter. The request is held back while the access path runs a page-mode burst. Once the backlog reaches its limit, an urgent flag is raised and the request goes up even during a burst, so the arbiter can pre-empt it. On a grant the block drives RAS and CAS itself for one CAS-before-RAS cycle. The address, write-enable and output-enable lines do not matter to these cycles and are not driven.

All timing limits are given as nanosecond parameters and converted to clock cycles from the clock period. Each limit is rounded up, except the refresh interval, which is rounded down.

Top module: `drfs_refresh_seq`

## Requirements
- R1: From reset release, RAS and CAS stay high (1), `init_done_o` stays low and no cycle starts for at least T_PAUSE = ceil(PAUSE_NS/period) cycles. An active reset returns every output to its idle value at once.
- R2: After the pause, INIT_CYCLES (default 8) refresh cycles run back to back with no grant. `init_done_o` rises only when the last one has completed, and `req_o` stays low while `init_done_o` is low.
- R3: In every refresh cycle CAS falls while RAS is high, and RAS falls only after CAS has been low for T_CSR cycles (at least 1).
- R4: RAS stays low for exactly T_RAS cycles. CAS stays low for T_CHR cycles after RAS falls, then rises while RAS is still low.
- R5: Between RAS pulses RAS stays high for at least T_RP cycles. CAS stays high for at least T_CPN cycles before it falls. Consecutive RAS falling edges are at least T_RC cycles apart.
- R6: After `init_done_o` rises, one refresh becomes owed every T_INT = floor(REFI_NS/period) cycles.
- R7: `req_o` is high when a refresh is owed, the engine is idle and no burst blocks it. CAS falls one cycle after a clock edge where `req_o` and `grant_i` are both high, and each completed cycle removes one owed refresh.
- R8: While `burst_busy_i` is high and the backlog is below BACKLOG_MAX, `req_o` stays low and owed refreshes accumulate.
- R9: The backlog saturates at BACKLOG_MAX (default 8). `urgent_o` is high exactly when it is full, and then `req_o` rises and a grant starts a cycle even with `burst_busy_i` high.
- R10: `busy_o` is high from the first CAS-low cycle to the end of RAS precharge, and `req_o` is low while `busy_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| grant_i | input | 1 | Arbiter grants the DRAM bus to the refresh engine |
| burst_busy_i | input | 1 | Access path is running a page-mode burst |
| req_o | output | 1 | Refresh request to the arbiter |
| urgent_o | output | 1 | Backlog full; arbiter should pre-empt any burst |
| busy_o | output | 1 | Engine is driving the strobes for a refresh cycle |
| init_done_o | output | 1 | Power-up pause and warm-up cycles finished |
| ras_n_o | output | 1 | Row strobe to the DRAM, active low |
| cas_n_o | output | 1 | Column strobe to the DRAM, active low |

## Verification
The assertions assume the following about the inputs:
- `grant_i` and `burst_busy_i` are synchronous to `clk`.
- The arbiter never lets the access path move the strobes while `busy_o` is high.
- The parameters give T_CHR below T_RAS and an interval longer than one refresh cycle.

The bench changes every input just after the falling clock edge. It raises `grant_i` only where a start is intended. It keeps the refresh interval at several times the length of a refresh cycle, so that drain phases never overlap a new tick.

// File: rtl/drfs_pkg.sv
package drfs_pkg;

  typedef enum logic [1:0] {
    ENG_IDLE   = 2'd0,
    ENG_CSETUP = 2'd1,
    ENG_RLOW   = 2'd2,
    ENG_RPRE   = 2'd3
  } eng_state_t;

  typedef enum logic [1:0] {
    PH_PAUSE = 2'd0,
    PH_INIT  = 2'd1,
    PH_RUN   = 2'd2
  } phase_t;

  function automatic int ns_to_cyc(input int ns, input int clk_ps);
    return (ns * 1000 + clk_ps - 1) / clk_ps;
  endfunction

  function automatic int at_least(input int v, input int lo);
    return (v < lo) ? lo : v;
  endfunction

endpackage

// File: rtl/drfs_interval_timer.sv
module drfs_interval_timer #(
  parameter int T_INT = 2000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  output logic tick_o
);
  localparam int TW = $clog2(T_INT + 1);
  localparam logic [TW-1:0] LAST = TW'(T_INT - 1);

  logic [TW-1:0] cnt_q, cnt_d;

  assign tick_o = en_i && (cnt_q == LAST);

  always_comb begin
    if (!en_i || tick_o) cnt_d = '0;
    else                 cnt_d = cnt_q + TW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // checker: spacing between consecutive ticks
  logic [TW:0] chk_gap;
  logic        chk_seen;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chk_gap  <= '0;
      chk_seen <= 1'b0;
    end else if (!en_i) begin
      chk_gap  <= '0;
      chk_seen <= 1'b0;
    end else if (tick_o) begin
      chk_gap  <= '0;
      chk_seen <= 1'b1;
    end else begin
      chk_gap  <= chk_gap + (TW+1)'(1);
    end
  end

  p_tick_period_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_o && chk_seen) |-> (chk_gap == (TW+1)'(T_INT - 1)));

endmodule

// File: rtl/drfs_backlog.sv
module drfs_backlog #(
  parameter int MAX = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic inc_i,
  input  logic dec_i,
  output logic pend_o,
  output logic full_o
);
  localparam int BW = $clog2(MAX + 1);
  localparam logic [BW-1:0] TOP = BW'(MAX);

  logic [BW-1:0] cnt_q, cnt_d;

  assign pend_o = (cnt_q != '0);
  assign full_o = (cnt_q == TOP);

  always_comb begin
    cnt_d = cnt_q;
    case ({inc_i, dec_i})
      2'b10:   if (!full_o) cnt_d = cnt_q + BW'(1);
      2'b01:   if (pend_o)  cnt_d = cnt_q - BW'(1);
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= TOP);

  p_sat_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (full_o && inc_i && !dec_i) |=> full_o);

  p_dec_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_i && !inc_i && cnt_q == BW'(1)) |=> !pend_o);

endmodule

// File: rtl/drfs_cbr_engine.sv
module drfs_cbr_engine
  import drfs_pkg::*;
#(
  parameter int T_CSR = 1,
  parameter int T_CHR = 2,
  parameter int T_RAS = 8,
  parameter int T_RP  = 5,
  parameter int T_CPN = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic idle_o,
  output logic done_o,
  output logic ras_n_o,
  output logic cas_n_o
);
  localparam int M1 = (T_CSR > T_RAS) ? T_CSR : T_RAS;
  localparam int M2 = (T_RP > T_CHR) ? T_RP : T_CHR;
  localparam int MAXLEN = (M1 > M2) ? M1 : M2;
  localparam int CW = $clog2(MAXLEN + 1);
  localparam logic [CW-1:0] LAST_CSR = CW'(T_CSR - 1);
  localparam logic [CW-1:0] LAST_RAS = CW'(T_RAS - 1);
  localparam logic [CW-1:0] LAST_RP  = CW'(T_RP - 1);
  localparam logic [CW-1:0] CHR_LEN  = CW'(T_CHR);

  eng_state_t    state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          ras_q, cas_q, ras_d, cas_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q + CW'(1);
    done_o  = 1'b0;
    case (state_q)
      ENG_IDLE: begin
        cnt_d = '0;
        if (start_i) state_d = ENG_CSETUP;
      end
      ENG_CSETUP: if (cnt_q == LAST_CSR) begin
        state_d = ENG_RLOW;
        cnt_d   = '0;
      end
      ENG_RLOW: if (cnt_q == LAST_RAS) begin
        state_d = ENG_RPRE;
        cnt_d   = '0;
      end
      ENG_RPRE: if (cnt_q == LAST_RP) begin
        state_d = ENG_IDLE;
        cnt_d   = '0;
        done_o  = 1'b1;
      end
      default: begin
        state_d = ENG_IDLE;
        cnt_d   = '0;
      end
    endcase
    ras_d = (state_d != ENG_RLOW);
    cas_d = !((state_d == ENG_CSETUP) ||
              ((state_d == ENG_RLOW) && (cnt_d < CHR_LEN)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ENG_IDLE;
      cnt_q   <= '0;
      ras_q   <= 1'b1;
      cas_q   <= 1'b1;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      ras_q   <= ras_d;
      cas_q   <= cas_d;
    end
  end

  assign idle_o  = (state_q == ENG_IDLE);
  assign ras_n_o = ras_q;
  assign cas_n_o = cas_q;

  // checker counters: run lengths of the strobe levels
  logic [15:0] chk_ras_lo, chk_ras_hi, chk_cas_hi;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chk_ras_lo <= '0;
      chk_ras_hi <= 16'hFFFF;
      chk_cas_hi <= 16'hFFFF;
    end else begin
      if (ras_q) chk_ras_lo <= '0;
      else if (chk_ras_lo != 16'hFFFF) chk_ras_lo <= chk_ras_lo + 16'd1;
      if (!ras_q) chk_ras_hi <= '0;
      else if (chk_ras_hi != 16'hFFFF) chk_ras_hi <= chk_ras_hi + 16'd1;
      if (!cas_q) chk_cas_hi <= '0;
      else if (chk_cas_hi != 16'hFFFF) chk_cas_hi <= chk_cas_hi + 16'd1;
    end
  end

  p_cbr_order_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_q) |-> !cas_q);

  p_cas_leads_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cas_q) |-> ras_q);

  p_ras_width_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_q) |-> (chk_ras_lo == 16'(T_RAS)));

  p_cas_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cas_q) |-> !ras_q);

  p_ras_precharge_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_q) |-> (chk_ras_hi >= 16'(T_RP)));

  p_cas_precharge_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cas_q) |-> (chk_cas_hi >= 16'(T_CPN)));

endmodule

// File: rtl/drfs_refresh_seq.sv
module drfs_refresh_seq
  import drfs_pkg::*;
#(
  parameter int CLK_PS      = 8000,
  parameter int PAUSE_NS    = 200000,
  parameter int REFI_NS     = 16000,
  parameter int RAS_NS      = 60,
  parameter int RP_NS       = 40,
  parameter int RC_NS       = 110,
  parameter int CHR_NS      = 10,
  parameter int CPN_NS      = 10,
  parameter int CSR_NS      = 0,
  parameter int INIT_CYCLES = 8,
  parameter int BACKLOG_MAX = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic grant_i,
  input  logic burst_busy_i,
  output logic req_o,
  output logic urgent_o,
  output logic busy_o,
  output logic init_done_o,
  output logic ras_n_o,
  output logic cas_n_o
);
  localparam int T_PAUSE = at_least(ns_to_cyc(PAUSE_NS, CLK_PS), 1);
  localparam int T_INT   = at_least((REFI_NS * 1000) / CLK_PS, 2);
  localparam int T_CSR   = at_least(ns_to_cyc(CSR_NS, CLK_PS), 1);
  localparam int T_CHR   = at_least(ns_to_cyc(CHR_NS, CLK_PS), 1);
  localparam int T_RAS   = at_least(ns_to_cyc(RAS_NS, CLK_PS), T_CHR + 1);
  localparam int T_CPN   = ns_to_cyc(CPN_NS, CLK_PS);
  localparam int T_RP0   = at_least(ns_to_cyc(RP_NS, CLK_PS), at_least(T_CPN, 1));
  localparam int T_RP    = at_least(T_RP0, ns_to_cyc(RC_NS, CLK_PS) - T_RAS - T_CSR);
  localparam int PW      = $clog2(T_PAUSE + 1);
  localparam int IW      = $clog2(INIT_CYCLES + 1);

  phase_t        phase_q, phase_d;
  logic [PW-1:0] pause_q, pause_d;
  logic [IW-1:0] initc_q, initc_d;

  logic eng_idle, eng_done, eng_start;
  logic tick, pend, full, run;

  assign run = (phase_q == PH_RUN);

  always_comb begin
    phase_d = phase_q;
    pause_d = pause_q;
    initc_d = initc_q;
    case (phase_q)
      PH_PAUSE: begin
        if (pause_q == PW'(T_PAUSE - 1)) phase_d = PH_INIT;
        else                             pause_d = pause_q + PW'(1);
      end
      PH_INIT: begin
        if (eng_done) begin
          if (initc_q == IW'(INIT_CYCLES - 1)) phase_d = PH_RUN;
          else                                 initc_d = initc_q + IW'(1);
        end
      end
      default: phase_d = phase_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_PAUSE;
      pause_q <= '0;
      initc_q <= '0;
    end else begin
      phase_q <= phase_d;
      pause_q <= pause_d;
      initc_q <= initc_d;
    end
  end

  assign req_o       = run && pend && eng_idle && (!burst_busy_i || full);
  assign eng_start   = ((phase_q == PH_INIT) && eng_idle) || (req_o && grant_i);
  assign urgent_o    = full;
  assign busy_o      = !eng_idle;
  assign init_done_o = run;

  drfs_interval_timer #(.T_INT(T_INT)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .en_i   (run),
    .tick_o (tick)
  );

  drfs_backlog #(.MAX(BACKLOG_MAX)) u_backlog (
    .clk    (clk),
    .rst_n  (rst_n),
    .inc_i  (tick),
    .dec_i  (eng_done && run),
    .pend_o (pend),
    .full_o (full)
  );

  drfs_cbr_engine #(
    .T_CSR (T_CSR),
    .T_CHR (T_CHR),
    .T_RAS (T_RAS),
    .T_RP  (T_RP),
    .T_CPN (T_CPN)
  ) u_engine (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (eng_start),
    .idle_o  (eng_idle),
    .done_o  (eng_done),
    .ras_n_o (ras_n_o),
    .cas_n_o (cas_n_o)
  );

  p_pause_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_PAUSE) |-> (ras_n_o && cas_n_o && !busy_o));

  p_req_gated_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !init_done_o |-> !req_o);

  p_grant_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_o && grant_i) |=> (!cas_n_o && busy_o));

  p_burst_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_busy_i && !urgent_o) |-> !req_o);

  p_urgent_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (urgent_o && !busy_o) |-> req_o);

  p_busy_noreq_r10: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> !req_o);

endmodule

// File: tb/drfs_refresh_seq_tb_top.sv
`timescale 1ns/1ps
module drfs_refresh_seq_tb_top;

  localparam int CLK_PS   = 8000;
  localparam int PAUSE_NS = 800;
  localparam int REFI_NS  = 2400;

  function automatic int cyc(input int ns);
    return (ns * 1000 + CLK_PS - 1) / CLK_PS;
  endfunction

  localparam int E_PAUSE = cyc(PAUSE_NS);
  localparam int E_INT   = (REFI_NS * 1000) / CLK_PS;
  localparam int E_CSR   = 1;
  localparam int E_CHR   = cyc(10);
  localparam int E_RAS   = cyc(60);
  localparam int E_RP    = cyc(40);
  localparam int E_CPN   = cyc(10);
  localparam int E_RC    = cyc(110);

  // rows: deferred intervals, expected refreshes on drain, expected urgent, expected req during burst
  localparam int NROW = 4;
  localparam int VEC [NROW][4] = '{
    '{1, 1, 0, 0},
    '{3, 3, 0, 0},
    '{8, 8, 1, 1},
    '{10, 8, 1, 1}
  };

  logic clk = 1'b0;
  logic rst_n, grant, burst;
  logic req, urgent, busy, init_done, ras_n, cas_n;

  always #4 clk = ~clk;

  drfs_refresh_seq #(
    .CLK_PS   (CLK_PS),
    .PAUSE_NS (PAUSE_NS),
    .REFI_NS  (REFI_NS)
  ) dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .grant_i      (grant),
    .burst_busy_i (burst),
    .req_o        (req),
    .urgent_o     (urgent),
    .busy_o       (busy),
    .init_done_o  (init_done),
    .ras_n_o      (ras_n),
    .cas_n_o      (cas_n)
  );

  int n_chk = 0;
  int n_fail = 0;

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  // strobe monitor
  int  ras_falls = 0;
  int  ras_lo_run, cas_lo_run, ras_hi_run, cas_hi_run, since_fall;
  int  last_csr, last_ras_lo, last_cas_lo;
  int  min_ras_hi = 1000000, min_cas_hi = 1000000, min_period = 1000000;
  bit  ras_p, cas_p, seen_fall, seen_cas;

  always @(negedge clk) begin
    if (!rst_n) begin
      ras_p = 1'b1; cas_p = 1'b1;
      ras_lo_run = 0; cas_lo_run = 0; ras_hi_run = 0; cas_hi_run = 0;
      since_fall = 0; seen_fall = 1'b0; seen_cas = 1'b0;
    end else begin
      since_fall++;
      if (ras_p && !ras_n) begin
        ras_falls++;
        last_csr = cas_lo_run;
        if (seen_fall) begin
          if (ras_hi_run < min_ras_hi) min_ras_hi = ras_hi_run;
          if (since_fall < min_period) min_period = since_fall;
        end
        seen_fall = 1'b1;
        since_fall = 0;
      end
      if (!ras_p && ras_n) last_ras_lo = ras_lo_run;
      if (!cas_p && cas_n) last_cas_lo = cas_lo_run;
      if (cas_p && !cas_n) begin
        if (seen_cas && cas_hi_run < min_cas_hi) min_cas_hi = cas_hi_run;
        seen_cas = 1'b1;
      end
      ras_lo_run = ras_n ? 0 : ras_lo_run + 1;
      ras_hi_run = ras_n ? ras_hi_run + 1 : 0;
      cas_lo_run = cas_n ? 0 : cas_lo_run + 1;
      cas_hi_run = cas_n ? cas_hi_run + 1 : 0;
      ras_p = ras_n;
      cas_p = cas_n;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
    $finish;
  end

  initial begin
    int cnt;
    int base;
    int bad;
    rst_n = 1'b0; grant = 1'b0; burst = 1'b0;
    repeat (5) step();
    // R1 reset state
    chk(ras_n && cas_n && !req && !urgent && !busy && !init_done, "R1 reset outputs",
        {ras_n, cas_n, req, urgent, busy, init_done}, 6'b110000);

    rst_n = 1'b1;
    cnt = 0; bad = 0;
    while (cas_n && cnt < 5000) begin
      if (!ras_n) bad++;
      step();
      cnt++;
    end
    chk(cnt >= E_PAUSE && cnt <= E_PAUSE + 2, "R1 pause length", cnt, E_PAUSE);
    chk(bad == 0, "R1 RAS high in pause", bad, 0);

    // R2 warm-up without grant
    cnt = 0; bad = 0;
    while (!init_done && cnt < 5000) begin
      if (req) bad++;
      step();
      cnt++;
    end
    chk(bad == 0, "R2 no request before ready", bad, 0);
    step();
    chk(ras_falls == 8, "R2 warm-up cycle count", ras_falls, 8);
    chk(ras_n && cas_n && !busy, "R2 idle after warm-up", {ras_n, cas_n, busy}, 3'b110);
    chk(last_csr == E_CSR, "R3 CAS lead before RAS", last_csr, E_CSR);
    chk(last_ras_lo == E_RAS, "R4 RAS low width", last_ras_lo, E_RAS);
    chk(last_cas_lo == E_CSR + E_CHR, "R4 CAS low width", last_cas_lo, E_CSR + E_CHR);
    chk(min_ras_hi >= E_RP, "R5 RAS precharge", min_ras_hi, E_RP);
    chk(min_cas_hi >= E_CPN, "R5 CAS precharge", min_cas_hi, E_CPN);
    chk(min_period >= E_RC, "R5 cycle time", min_period, E_RC);

    // R6 first interval, R7 grant handshake
    cnt = 1;
    while (!req && cnt < 5000) begin
      step();
      cnt++;
    end
    chk(cnt >= E_INT - 2 && cnt <= E_INT + 2, "R6 refresh interval", cnt, E_INT);
    chk(ras_falls == 8, "R7 no cycle without grant", ras_falls, 8);
    grant = 1'b1;
    step();
    chk(!cas_n && busy && !req, "R7 R10 start on grant", {cas_n, busy, req}, 3'b010);
    cnt = 0;
    while (busy && cnt < 100) begin
      if (req) bad++;
      step();
      cnt++;
    end
    chk(bad == 0, "R10 no request while busy", bad, 0);
    chk(!req && !urgent, "R7 backlog drained", {req, urgent}, 2'b00);

    // table of deferral scenarios
    for (int r = 0; r < NROW; r++) begin
      grant = 1'b1; burst = 1'b0;
      cnt = 0;
      while (ras_n && cnt < 1000) begin
        step();
        cnt++;
      end
      burst = 1'b1; grant = 1'b0;
      repeat (VEC[r][0] * E_INT) step();
      chk(urgent == VEC[r][2][0], "R9 urgent at backlog", urgent, VEC[r][2]);
      chk(req == VEC[r][3][0], "R8 R9 request during burst", req, VEC[r][3]);
      base = ras_falls;
      burst = 1'b0; grant = 1'b1;
      repeat (200) step();
      chk(ras_falls - base == VEC[r][1], "R9 R7 refreshes on drain", ras_falls - base, VEC[r][1]);
      chk(!urgent && !req, "R7 empty after drain", {urgent, req}, 2'b00);
    end

    // R9 pre-emption of a burst that is still running
    burst = 1'b1; grant = 1'b0;
    repeat (9 * E_INT) step();
    chk(urgent && req, "R9 urgent request with burst", {urgent, req}, 2'b11);
    grant = 1'b1;
    step();
    chk(!cas_n && busy, "R9 grant starts cycle during burst", {cas_n, busy}, 2'b01);
    burst = 1'b0;
    repeat (200) step();

    // R1 asynchronous reset mid-operation
    grant = 1'b0;
    while (!req) step();
    grant = 1'b1;
    step();
    step();
    #1 rst_n = 1'b0;
    #1;
    chk(ras_n && cas_n && !busy && !init_done && !req, "R1 reset mid-cycle",
        {ras_n, cas_n, busy, init_done, req}, 5'b11000);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule